// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects clocked on-chip logic to an external asynchronous static RAM with a 17-bit word address and a 16-bit data path split into two byte lanes. The user side posts one request at a time through a valid/ready handshake. Each request carries an address, a write flag, write data, a two-bit lane mask and a burst flag. Reads return through a one-cycle response pulse. Every memory timing limit is given in picoseconds and converted into whole clock cycles when the design is elaborated, so one parameter set covers any clock period.

Each operation takes four phases. In the first phase the address, data and lane mask are latched. A guard phase follows, where the address is driven and output enable is high. In the strobe phase, write enable or output enable is low for the counted number of cycles, together with the selected lane strobes. In the closing phase the strobes are released while address and data are still held.

For writes to consecutive words, setting the burst flag keeps write enable low between words. The lane strobes alone then open and close each word's write. Write enable goes high again as soon as the controller is idle and the next request is not another burst write.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is active and after its release, all memory control outputs (chip enable, write enable, output enable, both lane strobes, all active low) are high, the data drive enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: A write stores `req_wdata` on each enabled lane. A later read of the same address returns that data.
- R3: Mask bit 0 selects data bits 7:0 (strobe `mem_lane_n[0]`) and mask bit 1 selects bits 15:8 (strobe `mem_lane_n[1]`). A write leaves unselected lanes of the memory word unchanged. A read returns zero in unselected lanes.
- R4: A request with mask 00 is accepted in one cycle and no memory control pin changes. For a read, `rsp_valid` is high with zero data in the cycle after acceptance, and `req_ready` is high again in that same cycle.
- R5: During a write, write enable and each selected strobe stay low together for at least ceil(T_WRITE_PS/CLK_PS) cycles with a stable address. Data is driven, unchanged, in the cycle after the strobes rise.
- R6: Output enable is high in the cycle before write enable falls. The controller never drives the data bus while the memory drives it (chip enable low, write enable high, output enable low, a strobe low), nor in the cycle right after.
- R7: A read keeps output enable and the selected strobes low for ceil(T_ACCESS_PS/CLK_PS) cycles at a stable address before the data is captured. `rsp_valid` pulses in the cycle in which output enable rises again.
- R8: During back-to-back burst writes, write enable stays low between words while both strobes are high. It rises exactly once, when the controller is idle and the next request is not a burst write.
- R9: `req_ready` is high only while no strobe and no output enable is asserted. A read response arrives GUARD+RD+1 cycles after acceptance, where GUARD is ceil(T_TURN_PS/CLK_PS) and RD is the read count. After a non-burst write, ready returns GUARD+WR+2 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Keep write enable low after this write |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane strobes, bit 0 low byte, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from memory |

## Verification
A wrong phase or a corrupted cycle count shows up at the pins within the same operation. A write window that is too short is caught when the strobes rise. An early capture returns the filler value that the memory model drives before its access time has passed. A lost burst hold shows up as extra write enable rises before the next word starts. A lane mask latched incorrectly appears at the next read of that word, as a modified neighbour lane or as non-zero data in an unselected lane. A bus direction error is caught in the cycle where both sides drive the bus.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_END    = 2'd3
  } ctl_state_e;

  // whole clock cycles needed to cover a span, never fewer than one
  function automatic int cycles_for(input int span_ps, input int clk_ps);
    int c;
    c = (span_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? len : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              zero_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign masked[l*LANE_W +: LANE_W] = lane_en[l] ? din[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_en || zero_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en || zero_en) begin
      rdata_q <= cap_en ? masked : '0;
    end
  end

  assign rsp_valid = valid_q;
  assign rdata     = rdata_q;

  AST_ZERO_RSP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_en) && !$past(cap_en) |-> rdata == '0); // R4

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PS      = 8000,
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter int T_WRITE_PS  = 8000,
  parameter int T_ACCESS_PS = 10000,
  parameter int T_TURN_PS   = 4000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_burst,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int LANES     = DATA_W / 8;
  localparam int GUARD_CYC = cycles_for(T_TURN_PS, CLK_PS);
  localparam int WR_CYC    = cycles_for(T_WRITE_PS, CLK_PS);
  localparam int RD_CYC    = cycles_for(T_ACCESS_PS, CLK_PS);
  localparam int STRB_MAX  = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MAX_CYC   = (STRB_MAX > GUARD_CYC) ? STRB_MAX : GUARD_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  ctl_state_e        state_q, state_d;
  logic              op_write_q, op_burst_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [LANES-1:0]  op_mask_q;
  logic              we_held_q, we_held_d;
  logic              op_load;
  logic              accept;
  logic              burst_next;
  logic              tmr_start, tmr_last;
  logic [CNT_W-1:0]  tmr_len;
  logic              cap_en, zero_en;
  logic              strobe_on;

  // a held write enable only lets another burst write in
  assign burst_next = req_write && req_burst && (req_mask != '0);
  assign req_ready  = (state_q == ST_IDLE) && (!we_held_q || burst_next);
  assign accept     = req_valid && req_ready;

  always_comb begin
    state_d   = state_q;
    we_held_d = we_held_q;
    op_load   = 1'b0;
    tmr_start = 1'b0;
    tmr_len   = CNT_W'(GUARD_CYC);
    cap_en    = 1'b0;
    zero_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (we_held_q && !(accept && burst_next)) begin
          we_held_d = 1'b0;
        end
        if (accept && (req_mask != '0)) begin
          op_load   = 1'b1;
          tmr_start = 1'b1;
          state_d   = ST_SETUP;
        end else if (accept && !req_write) begin
          zero_en = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_last) begin
          tmr_start = 1'b1;
          tmr_len   = op_write_q ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
          state_d   = ST_ACTIVE;
          if (op_write_q && op_burst_q) begin
            we_held_d = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (tmr_last) begin
          cap_en  = !op_write_q;
          state_d = ST_END;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      we_held_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      we_held_q <= we_held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write_q <= 1'b0;
      op_burst_q <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      op_mask_q  <= '0;
    end else if (op_load) begin
      op_write_q <= req_write;
      op_burst_q <= req_burst;
      op_addr_q  <= req_addr;
      op_wdata_q <= req_wdata;
      op_mask_q  <= req_mask;
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  sram_read_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .zero_en   (zero_en),
    .lane_en   (op_mask_q),
    .din       (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rdata     (rsp_rdata)
  );

  // pin decode from registered state
  assign strobe_on  = (state_q == ST_ACTIVE);
  assign mem_addr   = op_addr_q;
  assign mem_ce_n   = !((state_q != ST_IDLE) || we_held_q);
  assign mem_we_n   = !((strobe_on && op_write_q) || we_held_q);
  assign mem_oe_n   = !(strobe_on && !op_write_q);
  assign mem_dq_out = op_wdata_q;
  assign mem_dq_oe  = op_write_q && (state_q != ST_IDLE);

  for (genvar l = 0; l < LANES; l++) begin : g_strobe
    assign mem_lane_n[l] = !(strobe_on && op_mask_q[l]);
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R6
  AST_WE_EXCLUDES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R6
  AST_WE_FALL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n)); // R6
  AST_READY_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_lane_n == '1) && mem_oe_n); // R9
  AST_RSP_ON_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lane_n[0]) && !$past(mem_we_n) |-> mem_dq_oe && $stable(mem_dq_out)); // R5

endmodule

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;

  localparam int CLK_PS = 8000;
  localparam int T_W    = 8000;
  localparam int T_A    = 10000;
  localparam int T_T    = 4000;

  function automatic int ceil_cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int GUARD = ceil_cyc(T_T);
  localparam int WRC   = ceil_cyc(T_W);
  localparam int RDC   = ceil_cyc(T_A);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h0F0F;

  always #4 clk = ~clk;

  sram_port_ctrl #(.CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] ram [int];
  logic [15:0] shadow [int];

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] r;
    r = old;
    if (m[0]) r[7:0]  = d[7:0];
    if (m[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  // behavioural memory with timing and contention checks
  bit          win_q [2];
  int          win_cnt [2];
  logic [16:0] win_addr [2];
  logic [15:0] dq_prev;
  bit          we_prev = 1'b1;
  bit          oe_prev = 1'b1;
  bit          drv_prev = 1'b0;
  int          oe_cnt = 0;
  logic [16:0] rd_addr;
  int          we_rises = 0;
  int          gap_samples = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit drv;
      cyc++;
      drv = !mem_ce_n && mem_we_n && !mem_oe_n && (mem_lane_n != 2'b11);
      check(!(mem_dq_oe && (drv || drv_prev)), "R6 bus contention", {31'd0, mem_dq_oe}, 32'd0);
      if (!mem_we_n && we_prev)
        check(oe_prev, "R6 oe high before we falls", {31'd0, oe_prev}, 32'd1);
      if (mem_we_n && !we_prev) we_rises++;
      if (!mem_ce_n && !mem_we_n && mem_lane_n == 2'b11) gap_samples++;
      if (req_ready)
        check(mem_lane_n == 2'b11 && mem_oe_n, "R9 ready while strobed", {30'd0, mem_lane_n}, 32'd3);
      for (int l = 0; l < 2; l++) begin
        bit w;
        w = !mem_ce_n && !mem_we_n && !mem_lane_n[l];
        if (w) begin
          if (!win_q[l]) begin
            win_cnt[l]  = 0;
            win_addr[l] = mem_addr;
          end
          win_cnt[l]++;
          if (mem_addr != win_addr[l])
            check(1'b0, "R5 address moved in write", {15'd0, mem_addr}, {15'd0, win_addr[l]});
        end else if (win_q[l]) begin
          logic [15:0] old;
          check(win_cnt[l] * CLK_PS >= T_W, "R5 write pulse width", win_cnt[l] * CLK_PS, T_W);
          check(mem_dq_oe && mem_dq_out[l*8 +: 8] == dq_prev[l*8 +: 8], "R5 data hold",
                {16'd0, mem_dq_out}, {16'd0, dq_prev});
          old = ram.exists(int'(win_addr[l])) ? ram[int'(win_addr[l])] : 16'h0000;
          old[l*8 +: 8] = dq_prev[l*8 +: 8];
          ram[int'(win_addr[l])] = old;
        end
        win_q[l] = w;
      end
      if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
        if (oe_cnt == 0) rd_addr = mem_addr;
        oe_cnt++;
        if (oe_cnt * CLK_PS >= T_A && mem_addr == rd_addr) begin
          logic [15:0] v;
          v = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
          mem_dq_in <= {mem_lane_n[1] ? 8'h5A : v[15:8], mem_lane_n[0] ? 8'h5A : v[7:0]};
        end else begin
          mem_dq_in <= 16'hBAD1;
        end
      end else begin
        oe_cnt = 0;
        mem_dq_in <= 16'h0F0F;
      end
      dq_prev  = mem_dq_out;
      we_prev  = mem_we_n;
      oe_prev  = mem_oe_n;
      drv_prev = drv;
      if (cyc > 150000) begin
        check(1'b0, "watchdog expired", cyc, 150000);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  // inputs change one time unit after a rising edge
  task automatic issue(input bit w, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit b);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m; req_burst = b;
    #1;
    while (!req_ready) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (w) shadow[int'(a)] = merge(shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000, d, m);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    int k;
    issue(1'b1, a, d, m, 1'b0);
    k = 1;
    while (!req_ready && k < 50) begin
      @(posedge clk); #1; k++;
    end
    if (m != 2'b00)
      check(k == GUARD + WRC + 2, "R9 write turnaround", k, GUARD + WRC + 2);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] m);
    int k;
    logic [15:0] e;
    issue(1'b0, a, 16'h0, m, 1'b0);
    k = 1;
    while (!rsp_valid && k < 50) begin
      @(posedge clk); #1; k++;
    end
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    e = {m[1] ? e[15:8] : 8'h00, m[0] ? e[7:0] : 8'h00};
    if (m == 2'b00) check(k == 1, "R4 empty read latency", k, 1);
    else            check(k == GUARD + RDC + 1, "R9 read latency", k, GUARD + RDC + 1);
    check(rsp_rdata == e, "R2 R3 R7 read data", {16'd0, rsp_rdata}, {16'd0, e});
    @(posedge clk); #1;
  endtask

  initial begin
    int base_rises;
    int base_gaps;
    repeat (3) @(posedge clk);
    #1;
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe && !rsp_valid,
          "R1 pins in reset", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n}, 32'h1f);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(req_ready && mem_ce_n && mem_we_n && !mem_dq_oe, "R1 after reset",
          {31'd0, req_ready}, 32'd1);

    do_write(17'h00010, 16'h1234, 2'b11);
    do_read (17'h00010, 2'b11);
    do_write(17'h1FFFF, 16'hBEEF, 2'b11);
    do_read (17'h1FFFF, 2'b11);

    // lane selection R3
    do_write(17'h00010, 16'hFF77, 2'b01);
    do_read (17'h00010, 2'b11);
    do_read (17'h00010, 2'b10);
    do_read (17'h00010, 2'b01);
    do_write(17'h00020, 16'hC3A5, 2'b10);
    do_read (17'h00020, 2'b11);

    // empty mask R4
    issue(1'b1, 17'h00010, 16'hFFFF, 2'b00, 1'b0);
    check(mem_ce_n && mem_we_n && mem_lane_n == 2'b11 && req_ready, "R4 empty write quiet",
          {29'd0, mem_ce_n, mem_lane_n}, 32'd7);
    do_read(17'h00010, 2'b11);
    do_read(17'h00011, 2'b00);
    do_read(17'h00033, 2'b11);

    // burst R8
    base_rises = we_rises;
    base_gaps  = gap_samples;
    issue(1'b1, 17'h00100, 16'h1111, 2'b11, 1'b1);
    issue(1'b1, 17'h00101, 16'h2222, 2'b10, 1'b1);
    issue(1'b1, 17'h00102, 16'h3333, 2'b01, 1'b1);
    do_read(17'h00100, 2'b11);
    check(we_rises - base_rises == 1, "R8 we rises in burst", we_rises - base_rises, 1);
    check(gap_samples > base_gaps, "R8 strobes frame words", gap_samples - base_gaps, 1);
    do_read(17'h00101, 2'b11);
    do_read(17'h00102, 2'b11);

    // non-burst back-to-back writes then reads
    base_rises = we_rises;
    do_write(17'h00200, 16'hA0A0, 2'b11);
    do_write(17'h00201, 16'h0B0B, 2'b11);
    check(we_rises - base_rises == 2, "R5 separate write pulses", we_rises - base_rises, 2);
    do_read(17'h00200, 2'b11);
    do_read(17'h00201, 2'b11);

    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule